// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Increment-Based Upper Sections

This block is a purely combinational adder. It returns `a + b + carry-in` as a sum word and a carry-out. The default word is 16 bits, and a parameter widens it. The operand bits are cut into sections whose widths grow from the least significant end.

The bottom section is an ordinary ripple adder driven by the external carry-in. Every section above it contains two parts:

- a single ripple adder that assumes no incoming carry;
- an incrementer that adds one to that adder's sum-and-carry vector.

The real carry leaving the section below chooses between the two candidates. When it is 0, the ripple result passes through. When it is 1, the incremented result passes through. This arrangement removes the second ripple adder that a classic carry-select section would need for the carry-in-one case.

The default 16-bit build has section widths 2, 2, 3, 4 and 5, counted from bit 0. Wider builds continue the series one bit larger each time (6, 7, 8, ...). The top section is shortened to fit the word. The carry-out is the carry chosen by the top section.

Top module: `csa_sqrt_adder`

## Requirements
- R1: For every value of `a_i`, `b_i` and `cin_i`, the concatenation `{cout_o, sum_o}` equals the full-precision sum `a_i + b_i + cin_i`.
- R2: Bits [1:0] of `sum_o` equal the low two bits of `a_i[1:0] + b_i[1:0] + cin_i`. They do not depend on any higher operand bit.
- R3: When `a_i ^ b_i` is all ones and `cin_i` is 1, `sum_o` is all zeros and `cout_o` is 1. The incoming carry ripples through every section.
- R4: The carry that enters each section equals the carry of the true addition into that section's least significant bit position. The section boundaries of the 16-bit build are bits 0, 2, 4, 7 and 11.
- R5: When both operands are all ones and `cin_i` is 1, `sum_o` is all ones and `cout_o` is 1.
- R6: With both operands zero and `cin_i` 0, `sum_o` is zero and `cout_o` is 0.
- R7: A 32-bit build, with sections 2, 2, 3, 4, 5, 6, 7 and a shortened top section of 3, satisfies R1 for its own width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach is the one where an upper section must take its incremented candidate while its own operand bits form a run of ones. That case needs a carry produced somewhere below to ripple across one or more whole sections.

The stimulus reaches it in three ways:

- operands shaped as `2^p - 1` plus one, for every position p;
- complementary operand pairs with carry-in set;
- all-ones operands.

Each way pushes the carry across every section boundary in turn. Random and exhaustive low-bit sweeps then cover the ordinary mixes of generated and propagated carries.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Nominal width of section k before it is fitted to the word:
    // 2, 2, 3, 4, 5, 6, ...
    function automatic int sec_width_raw(input int k);
        return (k == 0) ? 2 : k + 1;
    endfunction

    // Number of sections needed to cover a word of w bits.
    function automatic int sec_count(input int w);
        int acc;
        int k;
        acc = 0;
        k   = 0;
        while (acc < w) begin
            acc += sec_width_raw(k);
            k++;
        end
        return k;
    endfunction

    // Bit position of the least significant bit of section k.
    function automatic int sec_lsb(input int w, input int k);
        int acc;
        acc = 0;
        for (int j = 0; j < k; j++) begin
            acc += sec_width_raw(j);
        end
        return (acc > w) ? w : acc;
    endfunction

    // Width of section k; the top section is shortened to fit the word.
    function automatic int sec_width(input int w, input int k);
        int lo;
        int raw;
        lo  = sec_lsb(w, k);
        raw = sec_width_raw(k);
        return (lo + raw > w) ? (w - lo) : raw;
    endfunction

endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
    parameter int N = 4
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         cin_i,
    output logic [N-1:0] sum_o,
    output logic         cout_o
);
    logic [N:0] chain;

    assign chain[0] = cin_i;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic prop;
        assign prop         = a_i[i] ^ b_i[i];
        assign sum_o[i]     = prop ^ chain[i];
        assign chain[i + 1] = (a_i[i] & b_i[i]) | (prop & chain[i]);
    end

    assign cout_o = chain[N];
endmodule

// File: rtl/csa_excess1.sv
module csa_excess1 #(
    parameter int M = 5
) (
    input  logic [M-1:0] val_i,
    output logic [M-1:0] inc_o
);
    // run[i] is the AND of all input bits below bit i.
    logic [M-1:0] run;

    assign run[0] = 1'b1;

    for (genvar i = 0; i < M; i++) begin : g_bit
        assign inc_o[i] = val_i[i] ^ run[i];
        if (i < M - 1) begin : g_run
            assign run[i + 1] = run[i] & val_i[i];
        end
    end
endmodule

// File: rtl/csa_select_group.sv
module csa_select_group #(
    parameter int N = 3
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    input  logic         sel_i,
    output logic [N-1:0] sum_o,
    output logic         cout_o
);
    logic [N-1:0] sum_zero;
    logic         carry_zero;
    logic [N:0]   cand_zero;
    logic [N:0]   cand_one;
    logic [N:0]   chosen;

    csa_ripple #(.N(N)) u_rca (
        .a_i   (a_i),
        .b_i   (b_i),
        .cin_i (1'b0),
        .sum_o (sum_zero),
        .cout_o(carry_zero)
    );

    assign cand_zero = {carry_zero, sum_zero};

    csa_excess1 #(.M(N + 1)) u_inc (
        .val_i(cand_zero),
        .inc_o(cand_one)
    );

    always_comb begin
        chosen = sel_i ? cand_one : cand_zero;
    end

    assign sum_o  = chosen[N-1:0];
    assign cout_o = chosen[N];
endmodule

// File: rtl/csa_sqrt_adder.sv
module csa_sqrt_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam int NSEC = csa_pkg::sec_count(WIDTH);

    // sec_carry[k] is the carry entering section k.
    logic [NSEC:0] sec_carry;

    assign sec_carry[0] = cin_i;

    for (genvar k = 0; k < NSEC; k++) begin : g_sec
        localparam int LO = csa_pkg::sec_lsb(WIDTH, k);
        localparam int SW = csa_pkg::sec_width(WIDTH, k);

        if (k == 0) begin : g_direct
            csa_ripple #(.N(SW)) u_rca (
                .a_i   (a_i[LO +: SW]),
                .b_i   (b_i[LO +: SW]),
                .cin_i (sec_carry[k]),
                .sum_o (sum_o[LO +: SW]),
                .cout_o(sec_carry[k + 1])
            );
        end else begin : g_select
            csa_select_group #(.N(SW)) u_grp (
                .a_i   (a_i[LO +: SW]),
                .b_i   (b_i[LO +: SW]),
                .sel_i (sec_carry[k]),
                .sum_o (sum_o[LO +: SW]),
                .cout_o(sec_carry[k + 1])
            );
        end
    end

    assign cout_o = sec_carry[NSEC];
endmodule

// File: rtl/csa_sqrt_adder_chk.sv
module csa_sqrt_adder_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0]                        a_i,
    input logic [WIDTH-1:0]                        b_i,
    input logic                                    cin_i,
    input logic [WIDTH-1:0]                        sum_o,
    input logic                                    cout_o,
    input logic [csa_pkg::sec_count(WIDTH):0]      sec_carry
);
    localparam int NSEC = csa_pkg::sec_count(WIDTH);

    logic [WIDTH:0] full;
    logic [2:0]     low_ref;

    always_comb begin
        full    = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
        low_ref = {1'b0, a_i[1:0]} + {1'b0, b_i[1:0]} + {2'b00, cin_i};
    end

    always_comb begin
        p_sum_exact_r1: assert ({cout_o, sum_o} == full)
            else $error("R1 result %h expected %h", {cout_o, sum_o}, full);

        p_low_sector_r2: assert (sum_o[1:0] == low_ref[1:0])
            else $error("R2 low bits %b expected %b", sum_o[1:0], low_ref[1:0]);

        if (((a_i ^ b_i) == {WIDTH{1'b1}}) && cin_i) begin
            p_wrap_zero_r3: assert ((sum_o == '0) && cout_o)
                else $error("R3 wrap case gave %h", {cout_o, sum_o});
        end

        for (int k = 1; k < NSEC; k++) begin
            int lo;
            lo = csa_pkg::sec_lsb(WIDTH, k);
            p_sec_carry_r4: assert (sec_carry[k] == (full[lo] ^ a_i[lo] ^ b_i[lo]))
                else $error("R4 carry into section %0d wrong", k);
        end
    end
endmodule

bind csa_sqrt_adder csa_sqrt_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i      (a_i),
    .b_i      (b_i),
    .cin_i    (cin_i),
    .sum_o    (sum_o),
    .cout_o   (cout_o),
    .sec_carry(sec_carry)
);

// File: tb/test_csa_sqrt_adder.sv
module test_csa_sqrt_adder;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int WW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic [W-1:0]  a16 = '0;
    logic [W-1:0]  b16 = '0;
    logic          c16 = 1'b0;
    logic [W-1:0]  s16;
    logic          co16;

    logic [WW-1:0] a32 = '0;
    logic [WW-1:0] b32 = '0;
    logic          c32 = 1'b0;
    logic [WW-1:0] s32;
    logic          co32;

    int vectors = 0;
    int miscompares = 0;

    logic [W:0]  exp16_q[$];
    logic [WW:0] exp32_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    csa_sqrt_adder #(.WIDTH(W)) i_csa_sqrt_adder (
        .a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16), .cout_o(co16)
    );

    csa_sqrt_adder #(.WIDTH(WW)) i_csa_sqrt_adder_w32 (
        .a_i(a32), .b_i(b32), .cin_i(c32), .sum_o(s32), .cout_o(co32)
    );

    // Drive one vector on each instance at a rising edge, then compare
    // both results at the following falling edge.
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                         input logic [WW-1:0] wa, input logic [WW-1:0] wb, input logic wc,
                         input string tag);
        logic [W:0]  e16;
        logic [WW:0] e32;
        logic [2:0]  low;
        @(posedge clk);
        a16 = a; b16 = b; c16 = c;
        a32 = wa; b32 = wb; c32 = wc;
        exp16_q.push_back({1'b0, a} + {1'b0, b} + {{W{1'b0}}, c});
        exp32_q.push_back({1'b0, wa} + {1'b0, wb} + {{WW{1'b0}}, wc});
        @(negedge clk);
        e16 = exp16_q.pop_front();
        e32 = exp32_q.pop_front();
        low = {1'b0, a[1:0]} + {1'b0, b[1:0]} + {2'b00, c};
        vectors++;
        if ({co16, s16} !== e16) begin
            miscompares++;
            $display("FAIL %s: 16-bit result %h expected %h", tag, {co16, s16}, e16);
        end
        if (s16[1:0] !== low[1:0]) begin
            miscompares++;
            $display("FAIL R2: low sector %b expected %b", s16[1:0], low[1:0]);
        end
        if (co16 !== e16[W]) begin
            miscompares++;
            $display("FAIL R4: carry-out %b expected %b", co16, e16[W]);
        end
        if ({co32, s32} !== e32) begin
            miscompares++;
            $display("FAIL R7: 32-bit result %h expected %h", {co32, s32}, e32);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R6: zero operands after reset
        apply('0, '0, 1'b0, '0, '0, 1'b0, "R6");

        // R3: complementary operands with carry-in wrap every section
        apply(16'hFFFF, 16'h0000, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b1, "R3");
        apply(16'h5555, 16'hAAAA, 1'b1, 32'h5555_5555, 32'hAAAA_AAAA, 1'b1, "R3");
        apply(16'h0F0F, 16'hF0F0, 1'b1, 32'h00FF_00FF, 32'hFF00_FF00, 1'b1, "R3");

        // R5: both operands all ones with carry-in
        apply(16'hFFFF, 16'hFFFF, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R5");
        apply(16'hFFFF, 16'hFFFF, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R5");

        // R4: carry out of the top bit only
        apply(16'h8000, 16'h8000, 1'b0, 32'h8000_0000, 32'h8000_0000, 1'b0, "R4");

        // R4: a run of ones plus one carries across each section boundary
        for (int p = 1; p <= W; p++) begin
            logic [W-1:0] run16;
            run16 = (17'h1 << p) - 17'h1;
            apply(run16, 16'h0001, 1'b0, {16'h0, run16}, 32'h1, 1'b0, "R4");
            apply(run16, 16'h0000, 1'b1, {run16, 16'hFFFF}, 32'h0, 1'b1, "R4");
        end

        // R2: the low sector ignores higher bits
        for (int c = 0; c < 2; c++) begin
            apply(16'hABC3, 16'h1231, c[0], 32'h0, 32'h0, 1'b0, "R2");
        end

        // R1: exhaustive over six low bits, both carry-in values
        for (int x = 0; x < 64; x++) begin
            for (int y = 0; y < 64; y++) begin
                for (int c = 0; c < 2; c++) begin
                    apply(16'(x), 16'(y), c[0], 32'(x << 20), 32'(y << 20), c[0], "R1");
                end
            end
        end

        // R1 and R7: random operands
        for (int n = 0; n < 20000; n++) begin
            apply(16'($urandom), 16'($urandom), 1'($urandom), $urandom, $urandom,
                  1'($urandom), "R1");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule